// File: doc/BRIEF.md
# Switch Port Bridge Control Register

This block holds the bridge control word of a single port in a multi-port packet switch. Configuration software reads and writes it as one 32-bit dword with per-byte enables. The block also drives the side effects of the writable bits. One bit enables the reporting of poisoned packets seen on the secondary side. Another bit gates the error-message stream from the secondary side to the primary side. A third bit requests a hot reset of the link below the port.

The parameter `PORT_IDX` selects the variant. Index 0 is the upstream port. Its hot-reset bit does not reset a link of its own. Instead it raises a broadcast request, which the switch wires to the `hot_rst_bcast_in` pin of every downstream port. A downstream port holds its registered, active-low link reset while its own bit is set or the broadcast request is active. The two legacy display-decode bits exist only on ports up to `VGA_LAST_PORT`. On higher ports they read as zero.

The error-message path is a valid/ready stream. While forwarding is enabled, the secondary side's valid and kind pass straight to the primary side, and the primary side's ready is returned unchanged as back-pressure. While forwarding is disabled, every offered message is accepted at once and discarded, so the secondary side never stalls.

Top module: `brctl_port`

## Requirements
- R1: After reset, `cfg_rdata` reads 0, `port_rst_n` is 1, `hot_rst_bcast_out` is 0 and `poison_rpt` is 0.
- R2: A write with `cfg_be[2]`=1 stores bits 16 (poison reporting enable), 17 (error forwarding enable) and 22 (hot reset request), and the next read returns them.
- R3: A write with `cfg_be[2]`=0 leaves `cfg_rdata` unchanged. Byte enables 0, 1 and 3 never change any bit.
- R4: Bits 7:0, 15:8 (the interrupt pin field, value 00h), 21 and 31:23 always read 0, whatever was written.
- R5: On ports with `PORT_IDX` <= `VGA_LAST_PORT` (default 1), bits 19 and 20 are writable. On higher ports they read 0 and ignore writes.
- R6: `poison_rpt` is 1 in the cycle after `poison_seen`=1 only when bit 16 is 1. Otherwise it stays 0.
- R7: With bit 17 = 1, `pri_err_valid` equals `sec_err_valid` and `sec_err_ready` equals `pri_err_ready` in the same cycle. `pri_err_kind` equals `sec_err_kind` (0 correctable, 1 non-fatal, 2 fatal).
- R8: With bit 17 = 0, `pri_err_valid` is 0 and `sec_err_ready` is 1, so messages are dropped.
- R9: On a downstream port (`PORT_IDX`!=0), `port_rst_n` goes to 0 one clock after bit 22 becomes 1. It stays 0 while the bit is 1, and returns to 1 one clock after the bit clears, if no broadcast request is active.
- R10: On the upstream port, `hot_rst_bcast_out` follows bit 22 one clock later. Its own `port_rst_n` stays 1.
- R11: On a downstream port, `port_rst_n` is 0 one clock after `hot_rst_bcast_in` is 1, even when its own bit 22 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current register dword |
| poison_seen | input | 1 | Poisoned packet observed on the secondary side |
| poison_rpt | output | 1 | Registered poisoned-packet report |
| sec_err_valid | input | 1 | Secondary-side error message offered |
| sec_err_kind | input | 2 | Kind of the offered message |
| sec_err_ready | output | 1 | Message accepted from the secondary side |
| pri_err_valid | output | 1 | Message offered to the primary side |
| pri_err_kind | output | 2 | Kind of the forwarded message |
| pri_err_ready | input | 1 | Primary side accepts the message |
| hot_rst_bcast_in | input | 1 | Broadcast reset request from the upstream port |
| hot_rst_bcast_out | output | 1 | Broadcast reset request (driven on the upstream port only) |
| port_rst_n | output | 1 | Active-low link reset of this port |

## Verification
Assertions check these behaviours on every cycle. Writes without byte 2 leave the readback stable. The error stream either passes through or is swallowed, depending on the forwarding bit. A cleared poison enable keeps the report low. The reset outputs follow the hot-reset bit and the broadcast input one clock later. The bench shows what a property cannot. It sweeps every value of the control byte on three port variants and checks the masked readback. It also sweeps every byte-enable pattern. Directed sequences show the exact cycle at which each reset output changes, including the two-clock path from an upstream write to a downstream link reset.

// File: rtl/brctl_pkg.sv
`timescale 1ns/1ps
package brctl_pkg;
  localparam int DW     = 32;
  localparam int BEW    = DW / 8;
  localparam int KINDW  = 2;
  localparam int B_PERR = 16;
  localparam int B_EFWD = 17;
  localparam int B_VGA  = 19;
  localparam int B_VG16 = 20;
  localparam int B_SBR  = 22;
  localparam int INTPIN_LSB = 8;

  typedef enum logic [KINDW-1:0] {
    EK_COR  = 2'd0,
    EK_NONF = 2'd1,
    EK_FAT  = 2'd2,
    EK_RSV  = 2'd3
  } err_kind_e;

  function automatic logic [DW-1:0] wr_mask(input bit vga_ok);
    logic [DW-1:0] m;
    m = '0;
    m[B_PERR] = 1'b1;
    m[B_EFWD] = 1'b1;
    m[B_SBR]  = 1'b1;
    if (vga_ok) begin
      m[B_VGA]  = 1'b1;
      m[B_VG16] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/brctl_regs.sv
`timescale 1ns/1ps
module brctl_regs
  import brctl_pkg::*;
#(
  parameter bit         VGA_OK     = 1'b1,
  parameter logic [7:0] INTPIN_VAL = 8'h00
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr_en,
  input  logic [BEW-1:0] cfg_be,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  output logic           perr_en,
  output logic           efwd_en,
  output logic           sbr_req
);
  localparam logic [DW-1:0] WMASK = wr_mask(VGA_OK);

  logic [DW-1:0] lane_mask;
  logic [DW-1:0] upd_mask;
  logic [DW-1:0] store_q;

  for (genvar b = 0; b < BEW; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = {8{cfg_wr_en & cfg_be[b]}};
  end

  assign upd_mask = lane_mask & WMASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= (store_q & ~upd_mask) | (cfg_wdata & upd_mask);
  end

  always_comb begin
    cfg_rdata = store_q & WMASK;
    cfg_rdata[INTPIN_LSB +: 8] = INTPIN_VAL;
  end

  assign perr_en = store_q[B_PERR];
  assign efwd_en = store_q[B_EFWD];
  assign sbr_req = store_q[B_SBR];

  // R3: a write without byte lane 2 changes nothing visible
  p_be_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !cfg_be[2]) |=> $stable(cfg_rdata));
endmodule

// File: rtl/brctl_err_gate.sv
`timescale 1ns/1ps
module brctl_err_gate
  import brctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             efwd_en,
  input  logic             sec_err_valid,
  input  logic [KINDW-1:0] sec_err_kind,
  output logic             sec_err_ready,
  output logic             pri_err_valid,
  output logic [KINDW-1:0] pri_err_kind,
  input  logic             pri_err_ready
);
  always_comb begin
    pri_err_kind = sec_err_kind;
    if (efwd_en) begin
      pri_err_valid = sec_err_valid;
      sec_err_ready = pri_err_ready;
    end else begin
      pri_err_valid = 1'b0;
      sec_err_ready = 1'b1;
    end
  end

  // R8: blocked path swallows every offer
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !efwd_en |-> (sec_err_ready && !pri_err_valid));
  // R7: open path carries the offer and its kind
  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (efwd_en && sec_err_valid) |-> (pri_err_valid && pri_err_kind == sec_err_kind));
endmodule

// File: rtl/brctl_rst_fanout.sv
`timescale 1ns/1ps
module brctl_rst_fanout #(
  parameter bit IS_UP = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sbr_req,
  input  logic hot_rst_bcast_in,
  output logic hot_rst_bcast_out,
  output logic port_rst_n
);
  if (IS_UP) begin : g_up
    logic bcast_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bcast_q <= 1'b0;
      else        bcast_q <= sbr_req;
    end
    assign hot_rst_bcast_out = bcast_q;
    assign port_rst_n        = 1'b1;

    // R10: broadcast tracks the local request one clock later
    p_bcast_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sbr_req |=> hot_rst_bcast_out);
    p_bcast_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sbr_req |=> !hot_rst_bcast_out);
    // R10: the upstream link is never reset by a broadcast
    p_up_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hot_rst_bcast_in |=> port_rst_n);
  end else begin : g_dn
    logic rst_n_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_n_q <= 1'b1;
      else        rst_n_q <= ~(sbr_req | hot_rst_bcast_in);
    end
    assign port_rst_n        = rst_n_q;
    assign hot_rst_bcast_out = 1'b0;

    // R9: local request holds the link in reset
    p_rst_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sbr_req |=> !port_rst_n);
    // R11: broadcast alone holds the link in reset
    p_rst_bcast_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hot_rst_bcast_in |=> !port_rst_n);
    // R9: release once both sources drop
    p_rst_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sbr_req && !hot_rst_bcast_in) |=> port_rst_n);
  end
endmodule

// File: rtl/brctl_port.sv
`timescale 1ns/1ps
module brctl_port
  import brctl_pkg::*;
#(
  parameter int         PORT_IDX      = 0,
  parameter int         VGA_LAST_PORT = 1,
  parameter logic [7:0] INTPIN_VAL    = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [BEW-1:0]   cfg_be,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  input  logic             poison_seen,
  output logic             poison_rpt,
  input  logic             sec_err_valid,
  input  logic [KINDW-1:0] sec_err_kind,
  output logic             sec_err_ready,
  output logic             pri_err_valid,
  output logic [KINDW-1:0] pri_err_kind,
  input  logic             pri_err_ready,
  input  logic             hot_rst_bcast_in,
  output logic             hot_rst_bcast_out,
  output logic             port_rst_n
);
  localparam bit IS_UP  = (PORT_IDX == 0);
  localparam bit VGA_OK = (PORT_IDX <= VGA_LAST_PORT);

  logic perr_en, efwd_en, sbr_req;
  logic poison_q;

  brctl_regs #(.VGA_OK(VGA_OK), .INTPIN_VAL(INTPIN_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .perr_en(perr_en), .efwd_en(efwd_en), .sbr_req(sbr_req)
  );

  brctl_err_gate u_err (
    .clk(clk), .rst_n(rst_n), .efwd_en(efwd_en),
    .sec_err_valid(sec_err_valid), .sec_err_kind(sec_err_kind),
    .sec_err_ready(sec_err_ready), .pri_err_valid(pri_err_valid),
    .pri_err_kind(pri_err_kind), .pri_err_ready(pri_err_ready)
  );

  brctl_rst_fanout #(.IS_UP(IS_UP)) u_rst (
    .clk(clk), .rst_n(rst_n), .sbr_req(sbr_req),
    .hot_rst_bcast_in(hot_rst_bcast_in),
    .hot_rst_bcast_out(hot_rst_bcast_out), .port_rst_n(port_rst_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) poison_q <= 1'b0;
    else        poison_q <= poison_seen & perr_en;
  end
  assign poison_rpt = poison_q;

  // R6: a disabled enable keeps the report quiet
  p_poison_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_en |=> !poison_rpt);
  // R4: reserved upper nibble never reads as one
  p_resv_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:28] == 4'h0);
endmodule

// File: tb/test_brctl_port.sv
`timescale 1ns/1ps
module test_brctl_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  localparam int ND = 3;
  int pidx [ND] = '{0, 1, 3};

  logic        wr_en [ND];
  logic [3:0]  be;
  logic [31:0] wdata;
  logic [31:0] rdata [ND];
  logic        poison_seen;
  logic        poison_rpt [ND];
  logic        sec_valid, pri_ready;
  logic [1:0]  sec_kind;
  logic        sec_ready [ND];
  logic        pri_valid [ND];
  logic [1:0]  pri_kind [ND];
  logic        bcast_out [ND];
  logic        prst_n [ND];

  brctl_port #(.PORT_IDX(0)) i_brctl_port (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en[0]), .cfg_be(be), .cfg_wdata(wdata),
    .cfg_rdata(rdata[0]), .poison_seen(poison_seen), .poison_rpt(poison_rpt[0]),
    .sec_err_valid(sec_valid), .sec_err_kind(sec_kind), .sec_err_ready(sec_ready[0]),
    .pri_err_valid(pri_valid[0]), .pri_err_kind(pri_kind[0]), .pri_err_ready(pri_ready),
    .hot_rst_bcast_in(1'b0), .hot_rst_bcast_out(bcast_out[0]), .port_rst_n(prst_n[0]));

  brctl_port #(.PORT_IDX(1)) i_brctl_port_d1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en[1]), .cfg_be(be), .cfg_wdata(wdata),
    .cfg_rdata(rdata[1]), .poison_seen(poison_seen), .poison_rpt(poison_rpt[1]),
    .sec_err_valid(sec_valid), .sec_err_kind(sec_kind), .sec_err_ready(sec_ready[1]),
    .pri_err_valid(pri_valid[1]), .pri_err_kind(pri_kind[1]), .pri_err_ready(pri_ready),
    .hot_rst_bcast_in(bcast_out[0]), .hot_rst_bcast_out(bcast_out[1]), .port_rst_n(prst_n[1]));

  brctl_port #(.PORT_IDX(3)) i_brctl_port_d3 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en[2]), .cfg_be(be), .cfg_wdata(wdata),
    .cfg_rdata(rdata[2]), .poison_seen(poison_seen), .poison_rpt(poison_rpt[2]),
    .sec_err_valid(sec_valid), .sec_err_kind(sec_kind), .sec_err_ready(sec_ready[2]),
    .pri_err_valid(pri_valid[2]), .pri_err_kind(pri_kind[2]), .pri_err_ready(pri_ready),
    .hot_rst_bcast_in(bcast_out[0]), .hot_rst_bcast_out(bcast_out[2]), .port_rst_n(prst_n[2]));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] expq [ND];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] wmask(input int d);
    logic [31:0] m;
    m = (32'd1 << 16) | (32'd1 << 17) | (32'd1 << 22);
    if (pidx[d] <= 1) m = m | (32'd1 << 19) | (32'd1 << 20);
    return m;
  endfunction

  task automatic wr(input int d, input logic [3:0] b, input logic [31:0] v);
    logic [31:0] lm;
    @(negedge clk);
    wr_en[d] = 1'b1; be = b; wdata = v;
    @(negedge clk);
    wr_en[d] = 1'b0;
    lm = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
    expq[d] = (expq[d] & ~(lm & wmask(d))) | (v & lm & wmask(d));
    chk("R2/R3/R4/R5 readback", rdata[d], expq[d]);
  endtask

  task automatic settle_check();
    logic up22;
    up22 = expq[0][22];
    @(negedge clk); @(negedge clk);
    chk("R10 bcast_out", 32'(bcast_out[0]), 32'(up22));
    chk("R10 upstream own reset", 32'(prst_n[0]), 32'd1);
    for (int d = 1; d < ND; d++) begin
      chk("R9/R11 port_rst_n", 32'(prst_n[d]), 32'(!(expq[d][22] | up22)));
      chk("R10 dn bcast_out", 32'(bcast_out[d]), 32'd0);
    end
  endtask

  task automatic side_check(input int k);
    poison_seen = 1'b1;
    @(negedge clk);
    poison_seen = 1'b0;
    for (int d = 0; d < ND; d++) chk("R6 poison_rpt", 32'(poison_rpt[d]), 32'(expq[d][16]));
    @(negedge clk);
    for (int d = 0; d < ND; d++) chk("R6 poison idle", 32'(poison_rpt[d]), 32'd0);
    for (int pat = 0; pat < 4; pat++) begin
      sec_valid = pat[0]; pri_ready = pat[1]; sec_kind = 2'(k % 3);
      #1;
      for (int d = 0; d < ND; d++) begin
        if (expq[d][17]) begin
          chk("R7 pri_valid", 32'(pri_valid[d]), 32'(pat[0]));
          chk("R7 sec_ready", 32'(sec_ready[d]), 32'(pat[1]));
          chk("R7 pri_kind", 32'(pri_kind[d]), 32'(k % 3));
        end else begin
          chk("R8 pri_valid", 32'(pri_valid[d]), 32'd0);
          chk("R8 sec_ready", 32'(sec_ready[d]), 32'd1);
        end
      end
    end
    sec_valid = 1'b0; pri_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < ND; d++) begin wr_en[d] = 1'b0; expq[d] = '0; end
    be = '0; wdata = '0; poison_seen = 1'b0;
    sec_valid = 1'b0; pri_ready = 1'b0; sec_kind = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int d = 0; d < ND; d++) begin
      chk("R1 rdata", rdata[d], 32'd0);
      chk("R1 port_rst_n", 32'(prst_n[d]), 32'd1);
      chk("R1 bcast_out", 32'(bcast_out[d]), 32'd0);
      chk("R1 poison_rpt", 32'(poison_rpt[d]), 32'd0);
    end

    // R2 R4 R5 sweep of the control byte on every variant
    for (int v = 0; v < 256; v++) begin
      for (int d = 0; d < ND; d++) wr(d, 4'hF, {8'hFA, 8'(v), 8'h5A, 8'hC3});
      settle_check();
      side_check(v);
    end

    // R3 every byte-enable pattern
    for (int b = 0; b < 16; b++) begin
      for (int d = 0; d < ND; d++) begin
        wr(d, 4'(b), 32'hFFFF_FFFF);
        wr(d, 4'(b), 32'h0000_0000);
        wr(d, 4'(b ^ 4'hF), 32'hFFFF_FFFF);
      end
    end
    for (int d = 0; d < ND; d++) wr(d, 4'hF, 32'd0);
    settle_check();

    // R9 exact timing of the local reset
    wr(1, 4'h4, 32'h0040_0000);
    chk("R9 not yet", 32'(prst_n[1]), 32'd1);
    @(negedge clk);
    chk("R9 asserted", 32'(prst_n[1]), 32'd0);
    chk("R9 port3 unaffected", 32'(prst_n[2]), 32'd1);
    repeat (4) @(negedge clk);
    chk("R9 held", 32'(prst_n[1]), 32'd0);
    wr(1, 4'h4, 32'h0);
    chk("R9 still held", 32'(prst_n[1]), 32'd0);
    @(negedge clk);
    chk("R9 released", 32'(prst_n[1]), 32'd1);

    // R10 R11 broadcast path timing
    wr(0, 4'h4, 32'h0040_0000);
    chk("R10 bcast not yet", 32'(bcast_out[0]), 32'd0);
    @(negedge clk);
    chk("R10 bcast set", 32'(bcast_out[0]), 32'd1);
    chk("R11 dn not yet", 32'(prst_n[1]), 32'd1);
    @(negedge clk);
    chk("R11 dn1 reset", 32'(prst_n[1]), 32'd0);
    chk("R11 dn3 reset", 32'(prst_n[2]), 32'd0);
    chk("R10 up own", 32'(prst_n[0]), 32'd1);
    wr(0, 4'h4, 32'h0);
    @(negedge clk);
    chk("R10 bcast clear", 32'(bcast_out[0]), 32'd0);
    @(negedge clk);
    chk("R11 dn1 release", 32'(prst_n[1]), 32'd1);
    chk("R11 dn3 release", 32'(prst_n[2]), 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule